// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes one or more SDRAM devices from the power-up state to normal operation without help from software. After a one-cycle start pulse it holds the clock enable low for a long, configurable settling wait. It then raises the clock enable and issues the fixed bring-up series of commands on a registered command bus: a NOP, a precharge of all banks, a configurable number of auto-refresh commands, and a load of the mode register. A final load of the extended mode register follows only for low-power mobile parts. Gaps between commands are filled with NOPs. The lengths of these gaps are parameters in clock cycles, standing in for the row precharge time, the refresh cycle time and the mode-register delay.

The value for the standard mode register (CAS latency, burst length) and the value for the extended mode register (self-refresh temperature range, partial-array refresh, drive strength) come in on ports. They must be held stable while the sequence runs. The mobile select is captured on the same clock edge that accepts the start pulse. When the last gap has elapsed, a sticky done flag rises and the bus stays on NOP with the clock enable high until reset. Each wait parameter other than the power-up wait must be at least 2.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and afterwards until a start pulse, cke is 0, the bus is deselected (csN, rasN, casN, weN all 1), ba and addr are 0, and done is 0.
- R2: Count the clock edge that captures start as edge 0. From there cke stays 0 and csN stays 1 until cke rises after edge PWRUP_CYC+1.
- R3: The first command is a NOP (csN=0, rasN=1, casN=1, weN=1), issued one cycle after cke rises.
- R4: One cycle after the NOP, a precharge-all is issued: csN=0, rasN=0, casN=1, weN=0, with addr[10]=1.
- R5: Exactly REF_NUM auto-refresh commands (csN=0, rasN=0, casN=0, weN=1) follow. The first comes T_RP cycles after the precharge, and each later one comes T_RC cycles after the one before it.
- R6: T_RC cycles after the last refresh, a mode register load is issued (all four strobes 0) with ba=0 and addr equal to modeVal.
- R7: If mobileSel was high when start was captured, an extended mode register load (all four strobes 0) follows T_MRD cycles after the mode register load. It drives ba equal to the nonzero parameter EXT_BANK and addr equal to extModeVal.
- R8: If mobileSel was low when start was captured, no extended load is issued. The mode register load is the last command, whatever mobileSel does later.
- R9: From the first NOP onward, cke stays 1 and every cycle without a command carries a NOP.
- R10: done rises T_MRD cycles after the last mode-register command. It then stays 1, with the bus on NOP.
- R11: A start pulse has no effect once the sequence has begun or completed. Timing, command count and done are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins the sequence |
| mobileSel | input | 1 | Selects the mobile variant with the extended register step; sampled with start |
| modeVal | input | ADDR_W | Value driven on addr for the mode register load |
| extModeVal | input | ADDR_W | Value driven on addr for the extended mode register load |
| cke | output | 1 | SDRAM clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| done | output | 1 | Sticky flag: initialization complete |

## Verification
Every result is due a fixed number of edges after the edge that captures start. cke is due after edge PWRUP_CYC+1 and the NOP one edge later. The precharge comes one edge after the NOP, and each later command comes T_RP, T_RC or T_MRD edges after the one before it. done is due T_MRD edges after the final mode-register command. The bench samples on the falling edge and numbers each sample by the rising edges since start was captured. It logs every command with that index and compares the index with these sums, so a command that comes one cycle early or late, or is missing or extra, shows up as a mismatch.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [2:0] {
    CMD_INH, CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS, CMD_EMRS
  } cmd_e;

  typedef struct packed {
    cmd_e cmd;
    logic ckeOn;
    logic doneOn;
  } strobe_t;
endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC = 20000,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter int REF_NUM   = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    mobileSel,
  output strobe_t stb
);
  localparam int CNT_W = $clog2(PWRUP_CYC + T_RP + T_RC + T_MRD + 1);
  localparam int REF_W = $clog2(REF_NUM + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PWRUP, S_CKEUP, S_NOP, S_PRE, S_WRP, S_REF, S_WRC,
    S_MRS, S_WMRD, S_EMRS, S_WEMRD, S_DONE
  } state_e;

  state_e             state;
  logic [CNT_W-1:0]   waitCnt;
  logic [REF_W-1:0]   refLeft;
  logic               mobileQ;
  logic               waitZero;

  assign waitZero = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      refLeft <= '0;
      mobileQ <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_PWRUP;
          waitCnt <= CNT_W'(PWRUP_CYC - 1);
          mobileQ <= mobileSel;
        end
        S_PWRUP: if (waitZero) state <= S_CKEUP; else waitCnt <= waitCnt - 1'b1;
        S_CKEUP: state <= S_NOP;
        S_NOP:   state <= S_PRE;
        S_PRE: begin
          state   <= S_WRP;
          waitCnt <= CNT_W'(T_RP - 2);
          refLeft <= REF_W'(REF_NUM);
        end
        S_WRP: if (waitZero) state <= S_REF; else waitCnt <= waitCnt - 1'b1;
        S_REF: begin
          state   <= S_WRC;
          waitCnt <= CNT_W'(T_RC - 2);
          refLeft <= refLeft - 1'b1;
        end
        S_WRC: if (waitZero) state <= (refLeft == '0) ? S_MRS : S_REF;
               else waitCnt <= waitCnt - 1'b1;
        S_MRS: begin
          state   <= S_WMRD;
          waitCnt <= CNT_W'(T_MRD - 2);
        end
        S_WMRD: if (waitZero) state <= mobileQ ? S_EMRS : S_DONE;
                else waitCnt <= waitCnt - 1'b1;
        S_EMRS: begin
          state   <= S_WEMRD;
          waitCnt <= CNT_W'(T_MRD - 2);
        end
        S_WEMRD: if (waitZero) state <= S_DONE; else waitCnt <= waitCnt - 1'b1;
        S_DONE:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.ckeOn  = !(state == S_IDLE || state == S_PWRUP);
    stb.doneOn = (state == S_DONE);
    case (state)
      S_IDLE, S_PWRUP, S_CKEUP: stb.cmd = CMD_INH;
      S_PRE:                    stb.cmd = CMD_PRE;
      S_REF:                    stb.cmd = CMD_REF;
      S_MRS:                    stb.cmd = CMD_MRS;
      S_EMRS:                   stb.cmd = CMD_EMRS;
      default:                  stb.cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter logic [BA_W-1:0] EXT_BANK = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] modeVal,
  input  logic [ADDR_W-1:0] extModeVal,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  logic [3:0]        pinNext;
  logic [BA_W-1:0]   baNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    baNext   = '0;
    addrNext = '0;
    case (stb.cmd)
      CMD_NOP:  pinNext = 4'b0111;
      CMD_PRE: begin pinNext = 4'b0010; addrNext = ALL_BANKS; end
      CMD_REF:  pinNext = 4'b0001;
      CMD_MRS: begin pinNext = 4'b0000; addrNext = modeVal; end
      CMD_EMRS: begin pinNext = 4'b0000; addrNext = extModeVal; baNext = EXT_BANK; end
      default:  pinNext = 4'b1111;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {csN, rasN, casN, weN} <= 4'b1111;
      cke  <= 1'b0;
      ba   <= '0;
      addr <= '0;
      done <= 1'b0;
    end else begin
      {csN, rasN, casN, weN} <= pinNext;
      cke  <= stb.ckeOn;
      ba   <= baNext;
      addr <= addrNext;
      done <= stb.doneOn;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter logic [BA_W-1:0] EXT_BANK = 2'b10,
  parameter int PWRUP_CYC = 20000,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter int REF_NUM   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              mobileSel,
  input  logic [ADDR_W-1:0] modeVal,
  input  logic [ADDR_W-1:0] extModeVal,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  strobe_t stb;

  sdram_init_ctrl #(
    .PWRUP_CYC(PWRUP_CYC), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .REF_NUM(REF_NUM)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mobileSel(mobileSel), .stb(stb)
  );

  sdram_init_dp #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .EXT_BANK(EXT_BANK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .modeVal(modeVal), .extModeVal(extModeVal),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .done(done)
  );
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);
  // R2
  cke_low_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> csN);
  // R4
  pre_all_a10_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && !weN) |-> addr[10]);
  // R9
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke);
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);
  // R10
  done_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cke && !csN && rasN && casN && weN));
endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .ba(ba), .addr(addr), .done(done)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PWR  = 40;
  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int TMRD = 2;
  localparam int NREF = 8;
  localparam int AW   = 13;
  localparam int BAW  = 2;
  localparam logic [BAW-1:0] EXTB = 2'b10;
  localparam int LIMIT = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic mobileSel = 1'b0;
  logic [AW-1:0] modeVal = '0;
  logic [AW-1:0] extModeVal = '0;
  logic cke, csN, rasN, casN, weN, done;
  logic [BAW-1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(AW), .BA_W(BAW), .EXT_BANK(EXTB), .PWRUP_CYC(PWR),
    .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .REF_NUM(NREF)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mobileSel(mobileSel),
    .modeVal(modeVal), .extModeVal(extModeVal), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic reset_dut();
    rstN  = 1'b0;
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle values during reset
    check(cke === 1'b0 && done === 1'b0, "R1", "cke/done in reset", {cke, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: still idle after release without start
    check({csN, rasN, casN, weN} === 4'b1111, "R1", "bus deselected", {csN, rasN, casN, weN}, 15);
    check(ba === '0 && addr === '0 && cke === 1'b0 && done === 1'b0, "R1", "ba/addr/cke/done", int'(addr), 0);
  endtask

  task automatic run_seq(input bit mob, input bit poke, input logic [AW-1:0] mv,
                         input logic [AW-1:0] emv);
    int ckeAt = -1, doneAt = -1, firstLow = -1, nCmd = 0;
    int badIdle = 0, badGap = 0, doneDrop = 0;
    bit firstNop = 1'b0;
    int cmdAt[16];
    logic [2:0] cmdKind[16];
    logic [BAW-1:0] cmdBa[16];
    logic [AW-1:0] cmdAddr[16];
    int expCmds, lastAt, exp;

    mobileSel = mob;
    modeVal = mv;
    extModeVal = emv;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < LIMIT; i++) begin
      if (ckeAt < 0 && cke === 1'b1) ckeAt = i;
      if (doneAt < 0 && done === 1'b1) doneAt = i;
      if (doneAt >= 0 && done !== 1'b1) doneDrop++;
      if (cke !== 1'b1 && csN !== 1'b1) badIdle++;
      if (i > PWR + 1 && (csN !== 1'b0 || cke !== 1'b1)) badGap++;
      if (firstLow < 0 && csN === 1'b0) begin
        firstLow = i;
        firstNop = ({rasN, casN, weN} === 3'b111);
      end
      if (csN === 1'b0 && {rasN, casN, weN} !== 3'b111) begin
        if (nCmd < 16) begin
          cmdAt[nCmd] = i;
          cmdKind[nCmd] = {rasN, casN, weN};
          cmdBa[nCmd] = ba;
          cmdAddr[nCmd] = addr;
        end
        nCmd++;
      end
      // R11: start pulses during the run and after done
      if (poke && i == PWR + 10) begin start = 1'b1; mobileSel = !mob; end
      if (poke && i == PWR + 11) start = 1'b0;
      if (doneAt >= 0 && i == doneAt + 3) start = 1'b1;
      if (doneAt >= 0 && i == doneAt + 4) start = 1'b0;
      @(negedge clk);
    end
    mobileSel = mob;

    check(ckeAt == PWR + 1, "R2", "cke rise index", ckeAt, PWR + 1);
    check(badIdle == 0, "R2", "commands while cke low", badIdle, 0);
    check(firstLow == PWR + 2 && firstNop, "R3", "first NOP index", firstLow, PWR + 2);
    expCmds = NREF + 2 + (mob ? 1 : 0);
    check(nCmd == expCmds, mob ? "R7" : "R8", "command count", nCmd, expCmds);
    if (nCmd == expCmds) begin
      check(cmdAt[0] == PWR + 3 && cmdKind[0] == 3'b010 && cmdAddr[0][10] == 1'b1,
            "R4", "precharge-all index", cmdAt[0], PWR + 3);
      for (int k = 1; k <= NREF; k++) begin
        exp = PWR + 3 + TRP + (k - 1) * TRC;
        check(cmdAt[k] == exp && cmdKind[k] == 3'b001, "R5", "refresh index", cmdAt[k], exp);
      end
      exp = cmdAt[NREF] + TRC;
      check(cmdAt[NREF+1] == exp && cmdKind[NREF+1] == 3'b000, "R6", "mode load index",
            cmdAt[NREF+1], exp);
      check(cmdBa[NREF+1] == '0 && cmdAddr[NREF+1] == mv, "R6", "mode load ba/addr",
            int'(cmdAddr[NREF+1]), int'(mv));
      lastAt = cmdAt[NREF+1];
      if (mob) begin
        exp = lastAt + TMRD;
        check(cmdAt[NREF+2] == exp && cmdKind[NREF+2] == 3'b000, "R7", "ext load index",
              cmdAt[NREF+2], exp);
        check(cmdBa[NREF+2] == EXTB && cmdAddr[NREF+2] == emv, "R7", "ext load ba/addr",
              int'(cmdAddr[NREF+2]), int'(emv));
        lastAt = cmdAt[NREF+2];
      end
      check(doneAt == lastAt + TMRD, "R10", "done index", doneAt, lastAt + TMRD);
    end
    check(doneDrop == 0, "R10", "done dropped", doneDrop, 0);
    check(badGap == 0, poke ? "R11" : "R9", "non-NOP gap or cke drop", badGap, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reset_dut();
    run_seq(1'b0, 1'b0, 13'h0032, 13'h0000);
    reset_dut();
    run_seq(1'b1, 1'b1, 13'h0023, 13'h0041);
    reset_dut();
    run_seq(1'b0, 1'b1, 13'h0137, 13'h1FFF);
    reset_dut();
    run_seq(1'b1, 1'b0, 13'h1ABC, 13'h0F0F);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule